// File: doc/BRIEF.md
# Power Domain Switch Sequencer

The sequencer takes a gated logic domain down and back up in a fixed, safe order. A single request pulse selects the direction and says whether the domain carries SRAM. The block then walks a chain of one-cycle steps on the domain control bits. Where the physical side has to respond, it waits for a switch acknowledge, the SRAM acknowledge or the bus-protection sequencer, and each such wait is bounded by a timeout.

Before every sequence the block emits a one-cycle write strobe with a fixed unlock word for the configuration-enable register. On the way down it fences the bus first and powers down SRAM (when present). It then saves retention state, clamps the outputs, stops the clock, asserts reset and opens the two switch stages. The way up runs the reverse order. It adds a settle delay between the switch stages and a delay before reset release. It restores retention state only when an earlier power-down saved it.

`busy_o` is high while a sequence runs, and requests arriving in that time are dropped. The sequence ends with a one-cycle `done_o` or `err_o` pulse.

Top module: `pd_switch_seq`

## Requirements
- R1: Out of reset `busy_o`, `done_o` and `err_o` are 0 and the domain is off. `ctl_o` equals 9'h112, where bit 0 is reset_n, bit 1 is isolation, bit 2 is the primary switch, bit 3 is the secondary switch, bit 4 is clock disable and bit 8 is SRAM power-down. Bits 5 to 7 stay 0. The retention outputs are: clock disable 0, save 0, active-low restore 1.
- R2: Each accepted request first pulses `unlock_we_o` for one cycle while `unlock_o` is 32'h0B16_0001 (key 0xB16 in bits 31:16, bit 0 set).
- R3: Power-down order is fixed, with each step in its own cycle. First a bus-protection start with `bp_dir_o`=1, then a wait for `bp_done_i`. If SRAM is present, SRAM power-down is set and the block waits for `sram_ack_i`=1. Next, retention clock disable rises, the save strobe pulses high, and retention clock disable falls. After that isolation is set, then clock disable is set, then reset_n is cleared, then the primary switch is cleared.
- R4: After clearing the primary switch, the block waits for `pwr_ack_i`=0. It then clears the secondary switch, waits for `pwr_ack2_i`=0 and pulses `done_o`.
- R5: Power-up order: the primary switch is set and the block waits for `pwr_ack_i`=1. It then waits ON_SETTLE_US microseconds, sets the secondary switch and waits for `pwr_ack2_i`=1. The gap between the two switch edges is at least ON_SETTLE_US*US_CYCLES cycles.
- R6: After both switches are on, clock disable is cleared, then isolation is cleared. After at least RST_DLY_US*US_CYCLES cycles, reset_n is set.
- R7: A power-down that reaches the save step sets a saved flag. The next power-up restores after reset release: retention clock disable rises, restore pulses low, and clock disable falls. The flag then clears, so a later power-up with no power-down in between does no restore.
- R8: With SRAM absent (latched at request time), SRAM power-down is never changed in either direction.
- R9: In power-up, after reset release and any restore, SRAM power-down is cleared and the block waits for `sram_ack_i`=0 (SRAM present only). Bus protection is then released with `bp_dir_o`=0, and `done_o` follows `bp_done_i`.
- R10: A switch or SRAM acknowledge not reached within POLL_LIMIT*US_CYCLES cycles aborts the sequence with an `err_o` pulse. No later step is taken.
- R11: In power-up, a bus-protection error or timeout still ends with `done_o`, not `err_o`.
- R12: In power-down, `bp_err_i` together with `bp_done_i` ends the sequence with `err_o` and no further control change.
- R13: While `busy_o` is high, requests are ignored. `done_o` and `err_o` are single-cycle, mutually exclusive, and appear in the cycle `busy_o` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request pulse, taken when idle |
| req_on_i | input | 1 | 1 = power up, 0 = power down |
| has_sram_i | input | 1 | Domain has SRAM, latched with the request |
| pwr_ack_i | input | 1 | Primary switch acknowledge |
| pwr_ack2_i | input | 1 | Secondary switch acknowledge |
| sram_ack_i | input | 1 | SRAM power-down acknowledge |
| bp_done_i | input | 1 | Bus-protection sequencer finished |
| bp_err_i | input | 1 | Bus-protection failure, valid with done |
| ctl_o | output | 9 | Domain control bits (see R1) |
| ret_clk_dis_o | output | 1 | Retention clock disable |
| ret_save_o | output | 1 | Retention save strobe |
| ret_nrestore_o | output | 1 | Retention restore strobe, active low |
| bp_start_o | output | 1 | Bus-protection start pulse |
| bp_dir_o | output | 1 | 1 = protect, 0 = release |
| unlock_we_o | output | 1 | Unlock word write strobe |
| unlock_o | output | 32 | Unlock word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Sequence aborted on timeout or error |

## Verification
The hardest state to reach is a domain stranded halfway down. The primary acknowledge never falls, so the sequence aborts after isolation and reset are already applied. The bench model pins the primary acknowledge high for one power-down and measures the error pulse against the switch edge. It then frees the acknowledge and issues a second power-down that must complete from the stranded state. The saved-flag path is reached by chaining sequences. A power-down is followed by two power-ups, so the restore pulse must appear in the first power-up and be missing from the second.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;
  localparam int CTL_W      = 9;
  localparam int CTL_RSTN   = 0;
  localparam int CTL_ISO    = 1;
  localparam int CTL_ON     = 2;
  localparam int CTL_ON2    = 3;
  localparam int CTL_CLKDIS = 4;
  localparam int CTL_SRAM   = 8;
  localparam logic [CTL_W-1:0] CTL_RESET  = 9'h112;
  localparam logic [31:0]      UNLOCK_KEY = 32'h0B16_0001;

  typedef enum logic [5:0] {
    S_IDLE, S_UNLOCK,
    D_BP, D_BPW, D_SRAM, D_SRAMW, D_RCLK, D_SAVE, D_UNSAVE, D_RCLKOFF,
    D_ISO, D_CLK, D_RST, D_OFF1, D_W1, D_OFF2, D_W2,
    U_ON1, U_W1, U_SETTLE, U_ON2, U_W2, U_CLK, U_ISO, U_RDLY, U_RST,
    R_CLK, R_LO, R_HI, R_CLKOFF, U_SRAM, U_SRAMW, U_BP, U_BPW
  } seq_state_e;
endpackage

// File: rtl/pd_wait_timer.sv
module pd_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  // expires in the lim_i-th cycle after the clear
  assign expired_o = (cnt_q == lim_i - 1'b1);
endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int TMO_CYC    = 100,
  parameter int SETTLE_CYC = 10,
  parameter int RDLY_CYC   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_on_i,
  input  logic             has_sram_i,
  input  logic             pwr_ack_i,
  input  logic             pwr_ack2_i,
  input  logic             sram_ack_i,
  input  logic             bp_done_i,
  input  logic             bp_err_i,
  input  logic             expired_i,
  output logic             tmr_clr_o,
  output logic [CNT_W-1:0] tmr_lim_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             ret_clk_dis_o,
  output logic             ret_save_o,
  output logic             ret_nrestore_o,
  output logic             bp_start_o,
  output logic             bp_dir_o,
  output logic             unlock_we_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] TMO_L    = CNT_W'(TMO_CYC);
  localparam logic [CNT_W-1:0] SETTLE_L = CNT_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0] RDLY_L   = CNT_W'(RDLY_CYC);

  seq_state_e state_q, state_d;
  logic [CTL_W-1:0] ctl_q;
  logic on_q, sram_q, flag_q, fin_ok, fin_err;
  logic ret_clk_q, save_q, nres_q, bp_start_q, bp_dir_q, unlock_we_q, done_q, err_q;

  always_comb begin
    state_d   = state_q;
    tmr_lim_o = TMO_L;
    fin_ok    = 1'b0;
    fin_err   = 1'b0;
    unique case (state_q)
      S_IDLE:    if (req_i) state_d = S_UNLOCK;
      S_UNLOCK:  state_d = on_q ? U_ON1 : D_BP;
      D_BP:      state_d = D_BPW;
      D_BPW: begin
        if (bp_done_i) begin
          if (bp_err_i) begin state_d = S_IDLE; fin_err = 1'b1; end
          else state_d = sram_q ? D_SRAM : D_RCLK;
        end else if (expired_i) begin state_d = S_IDLE; fin_err = 1'b1; end
      end
      D_SRAM:    state_d = D_SRAMW;
      D_SRAMW: begin
        if (sram_ack_i) state_d = D_RCLK;
        else if (expired_i) begin state_d = S_IDLE; fin_err = 1'b1; end
      end
      D_RCLK:    state_d = D_SAVE;
      D_SAVE:    state_d = D_UNSAVE;
      D_UNSAVE:  state_d = D_RCLKOFF;
      D_RCLKOFF: state_d = D_ISO;
      D_ISO:     state_d = D_CLK;
      D_CLK:     state_d = D_RST;
      D_RST:     state_d = D_OFF1;
      D_OFF1:    state_d = D_W1;
      D_W1: begin
        if (!pwr_ack_i) state_d = D_OFF2;
        else if (expired_i) begin state_d = S_IDLE; fin_err = 1'b1; end
      end
      D_OFF2:    state_d = D_W2;
      D_W2: begin
        if (!pwr_ack2_i) begin state_d = S_IDLE; fin_ok = 1'b1; end
        else if (expired_i) begin state_d = S_IDLE; fin_err = 1'b1; end
      end
      U_ON1:     state_d = U_W1;
      U_W1: begin
        if (pwr_ack_i) state_d = U_SETTLE;
        else if (expired_i) begin state_d = S_IDLE; fin_err = 1'b1; end
      end
      U_SETTLE: begin
        tmr_lim_o = SETTLE_L;
        if (expired_i) state_d = U_ON2;
      end
      U_ON2:     state_d = U_W2;
      U_W2: begin
        if (pwr_ack2_i) state_d = U_CLK;
        else if (expired_i) begin state_d = S_IDLE; fin_err = 1'b1; end
      end
      U_CLK:     state_d = U_ISO;
      U_ISO:     state_d = U_RDLY;
      U_RDLY: begin
        tmr_lim_o = RDLY_L;
        if (expired_i) state_d = U_RST;
      end
      U_RST:     state_d = flag_q ? R_CLK : (sram_q ? U_SRAM : U_BP);
      R_CLK:     state_d = R_LO;
      R_LO:      state_d = R_HI;
      R_HI:      state_d = R_CLKOFF;
      R_CLKOFF:  state_d = sram_q ? U_SRAM : U_BP;
      U_SRAM:    state_d = U_SRAMW;
      U_SRAMW: begin
        if (!sram_ack_i) state_d = U_BP;
        else if (expired_i) begin state_d = S_IDLE; fin_err = 1'b1; end
      end
      U_BP:      state_d = U_BPW;
      // release failures are not reported
      U_BPW:     if (bp_done_i || expired_i) begin state_d = S_IDLE; fin_ok = 1'b1; end
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      ctl_q       <= CTL_RESET;
      on_q        <= 1'b0;
      sram_q      <= 1'b0;
      flag_q      <= 1'b0;
      ret_clk_q   <= 1'b0;
      save_q      <= 1'b0;
      nres_q      <= 1'b1;
      bp_start_q  <= 1'b0;
      bp_dir_q    <= 1'b0;
      unlock_we_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      bp_start_q  <= 1'b0;
      unlock_we_q <= 1'b0;
      done_q      <= fin_ok;
      err_q       <= fin_err;
      if (state_q == S_IDLE && req_i) begin
        on_q   <= req_on_i;
        sram_q <= has_sram_i;
      end
      unique case (state_q)
        S_UNLOCK:  unlock_we_q <= 1'b1;
        D_BP:      begin bp_start_q <= 1'b1; bp_dir_q <= 1'b1; end
        D_SRAM:    ctl_q[CTL_SRAM] <= 1'b1;
        D_RCLK:    ret_clk_q <= 1'b1;
        D_SAVE:    save_q <= 1'b1;
        D_UNSAVE:  save_q <= 1'b0;
        D_RCLKOFF: begin ret_clk_q <= 1'b0; flag_q <= 1'b1; end
        D_ISO:     ctl_q[CTL_ISO] <= 1'b1;
        D_CLK:     ctl_q[CTL_CLKDIS] <= 1'b1;
        D_RST:     ctl_q[CTL_RSTN] <= 1'b0;
        D_OFF1:    ctl_q[CTL_ON] <= 1'b0;
        D_OFF2:    ctl_q[CTL_ON2] <= 1'b0;
        U_ON1:     ctl_q[CTL_ON] <= 1'b1;
        U_ON2:     ctl_q[CTL_ON2] <= 1'b1;
        U_CLK:     ctl_q[CTL_CLKDIS] <= 1'b0;
        U_ISO:     ctl_q[CTL_ISO] <= 1'b0;
        U_RST:     ctl_q[CTL_RSTN] <= 1'b1;
        R_CLK:     ret_clk_q <= 1'b1;
        R_LO:      nres_q <= 1'b0;
        R_HI:      nres_q <= 1'b1;
        R_CLKOFF:  begin ret_clk_q <= 1'b0; flag_q <= 1'b0; end
        U_SRAM:    ctl_q[CTL_SRAM] <= 1'b0;
        U_BP:      begin bp_start_q <= 1'b1; bp_dir_q <= 1'b0; end
        default:   ;
      endcase
    end
  end

  assign tmr_clr_o      = (state_q != state_d);
  assign busy_o         = (state_q != S_IDLE);
  assign ctl_o          = ctl_q;
  assign ret_clk_dis_o  = ret_clk_q;
  assign ret_save_o     = save_q;
  assign ret_nrestore_o = nres_q;
  assign bp_start_o     = bp_start_q;
  assign bp_dir_o       = bp_dir_q;
  assign unlock_we_o    = unlock_we_q;
  assign done_o         = done_q;
  assign err_o          = err_q;

  // R13
  end_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, err_o}));
  // R13
  end_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
  // R2
  unlock_in_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_we_o |-> busy_o);
  // R3
  save_framed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_save_o |-> ret_clk_dis_o);
  // R7
  restore_framed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_nrestore_o |-> ret_clk_dis_o);
  // R3
  off_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[CTL_ON] |-> (!ctl_o[CTL_RSTN] && ctl_o[CTL_ISO]));
  // R6
  iso_open_powered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o[CTL_ISO] |-> (ctl_o[CTL_ON] && ctl_o[CTL_ON2]));
endmodule

// File: rtl/pd_switch_seq.sv
module pd_switch_seq
  import pd_seq_pkg::*;
#(
  parameter int US_CYCLES    = 100,
  parameter int POLL_LIMIT   = 500,
  parameter int ON_SETTLE_US = 50,
  parameter int RST_DLY_US   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_on_i,
  input  logic             has_sram_i,
  input  logic             pwr_ack_i,
  input  logic             pwr_ack2_i,
  input  logic             sram_ack_i,
  input  logic             bp_done_i,
  input  logic             bp_err_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             ret_clk_dis_o,
  output logic             ret_save_o,
  output logic             ret_nrestore_o,
  output logic             bp_start_o,
  output logic             bp_dir_o,
  output logic             unlock_we_o,
  output logic [31:0]      unlock_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int TMO_CYC    = POLL_LIMIT * US_CYCLES;
  localparam int SETTLE_CYC = ON_SETTLE_US * US_CYCLES;
  localparam int RDLY_CYC   = RST_DLY_US * US_CYCLES;
  localparam int MAX_CYC    = (TMO_CYC > SETTLE_CYC) ?
                              ((TMO_CYC > RDLY_CYC) ? TMO_CYC : RDLY_CYC) :
                              ((SETTLE_CYC > RDLY_CYC) ? SETTLE_CYC : RDLY_CYC);
  localparam int CNT_W      = $clog2(MAX_CYC + 1) + 1;

  logic             tmr_clr, tmr_exp;
  logic [CNT_W-1:0] tmr_lim;

  pd_wait_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .lim_i     (tmr_lim),
    .expired_o (tmr_exp)
  );

  pd_seq_fsm #(
    .CNT_W      (CNT_W),
    .TMO_CYC    (TMO_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .RDLY_CYC   (RDLY_CYC)
  ) i_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_i          (req_i),
    .req_on_i       (req_on_i),
    .has_sram_i     (has_sram_i),
    .pwr_ack_i      (pwr_ack_i),
    .pwr_ack2_i     (pwr_ack2_i),
    .sram_ack_i     (sram_ack_i),
    .bp_done_i      (bp_done_i),
    .bp_err_i       (bp_err_i),
    .expired_i      (tmr_exp),
    .tmr_clr_o      (tmr_clr),
    .tmr_lim_o      (tmr_lim),
    .ctl_o          (ctl_o),
    .ret_clk_dis_o  (ret_clk_dis_o),
    .ret_save_o     (ret_save_o),
    .ret_nrestore_o (ret_nrestore_o),
    .bp_start_o     (bp_start_o),
    .bp_dir_o       (bp_dir_o),
    .unlock_we_o    (unlock_we_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o)
  );

  assign unlock_o = UNLOCK_KEY;
endmodule

// File: tb/test_pd_switch_seq.sv
`timescale 1ns/1ps
module test_pd_switch_seq;
  localparam int US  = 2;
  localparam int TMO = 500 * US;
  localparam int SET = 50 * US;
  localparam int RDL = 10 * US;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, req_on_i = 1'b0, has_sram_i = 1'b0;
  logic pwr_ack_i, pwr_ack2_i, sram_ack_i;
  logic bp_done_i = 1'b0, bp_err_i = 1'b0;
  logic [8:0] ctl_o;
  logic ret_clk_dis_o, ret_save_o, ret_nrestore_o, bp_start_o, bp_dir_o, unlock_we_o;
  logic [31:0] unlock_o;
  logic busy_o, done_o, err_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  bit ack_stuck = 0, bp_err_mode = 0;
  logic [2:0] ack_sr = '0, ack2_sr = '0, sram_sr = '0;
  int bp_cnt = 0;
  int ev_q[$];
  int t_q[$];
  logic [13:0] prev_snap = '0;
  logic [31:0] seen_unlock = '0;
  logic seen_dir = 1'b0;

  always #5 clk_i = ~clk_i;

  pd_switch_seq #(.US_CYCLES(US)) i_pd_switch_seq (.*);

  // domain and bus-protection models
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    ack_sr  <= {ack_sr[1:0], ctl_o[2]};
    ack2_sr <= {ack2_sr[1:0], ctl_o[3]};
    sram_sr <= {sram_sr[1:0], ctl_o[8]};
    if (bp_start_o) bp_cnt <= 3;
    else if (bp_cnt != 0) bp_cnt <= bp_cnt - 1;
    bp_done_i <= (bp_cnt == 1);
    bp_err_i  <= (bp_cnt == 1) && bp_err_mode;
  end
  assign pwr_ack_i  = ack_stuck ? 1'b1 : ack_sr[2];
  assign pwr_ack2_i = ack2_sr[2];
  assign sram_ack_i = sram_sr[2];

  function automatic logic [13:0] snap();
    return {unlock_we_o, bp_start_o, ret_nrestore_o, ret_save_o, ret_clk_dis_o,
            ctl_o[8], 3'b000, ctl_o[4:0]};
  endfunction

  // event log: code = 2*id + new value
  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [13:0] s;
      s = snap();
      for (int k = 0; k < 14; k++) begin
        if (s[k] != prev_snap[k] && (k < 12 || s[k])) begin
          ev_q.push_back(2*k + int'(s[k]));
          t_q.push_back(cyc);
          if (k == 13) seen_unlock = unlock_o;
          if (k == 12) seen_dir = bp_dir_o;
        end
      end
      prev_snap = s;
    end else prev_snap = snap();
  end

  always @(posedge clk_i) begin
    if (cyc > 150000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung (act cyc=%0d exp <150000)", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp_v);
    end
  endtask

  task automatic chk_seq(string req, int exp_v[]);
    bit ok = (ev_q.size() == exp_v.size());
    n_chk++;
    if (ok) foreach (exp_v[i]) if (ev_q[i] != exp_v[i]) ok = 0;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%p exp=%p", req, ev_q, exp_v);
    end
  endtask

  function automatic int t_of(int code);
    foreach (ev_q[i]) if (ev_q[i] == code) return t_q[i];
    return -1;
  endfunction

  task automatic start_req(bit on, bit sram);
    ev_q.delete(); t_q.delete();
    @(negedge clk_i);
    req_i = 1'b1; req_on_i = on; has_sram_i = sram;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_end(output bit d, output bit e, output int t);
    while (!(done_o || err_o)) @(negedge clk_i);
    d = done_o; e = err_o; t = cyc;
    @(negedge clk_i);
    chk("R13 pulse width", {30'd0, done_o, err_o}, 32'd0);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 done/err", {done_o, err_o}, 0);
    chk("R1 ctl", ctl_o, 9'h112);
    chk("R1 retention", {ret_clk_dis_o, ret_save_o, ret_nrestore_o}, 3'b001);
  endtask

  task automatic t_up_first();
    bit d, e; int t, n;
    start_req(1, 1);
    chk("R13 busy", busy_o, 1);
    repeat (5) @(negedge clk_i);
    req_i = 1'b1; req_on_i = 1'b0;   // must be dropped
    @(negedge clk_i); req_i = 1'b0;
    wait_end(d, e, t);
    chk("R9 done", {d, e}, 2'b10);
    chk_seq("R5 R6 R9 up order, no restore R7", '{27, 5, 7, 8, 2, 1, 16, 25});
    chk("R2 unlock word", seen_unlock, 32'h0B16_0001);
    chk("R9 release dir", seen_dir, 0);
    chk("R5 settle gap", (t_of(7) - t_of(5) >= SET), 1);
    chk("R6 reset delay", (t_of(1) - t_of(2) >= RDL), 1);
    n = ev_q.size();
    repeat (10) @(negedge clk_i);
    chk("R13 dropped request", {busy_o, 31'(ev_q.size())}, {1'b0, 31'(n)});
  endtask

  task automatic t_down(bit sram, int exp_v[], string tag);
    bit d, e; int t;
    start_req(0, sram);
    wait_end(d, e, t);
    chk({tag, " done"}, {d, e}, 2'b10);
    chk_seq(tag, exp_v);
    chk({tag, " protect dir"}, seen_dir, 1);
  endtask

  task automatic t_up(bit sram, int exp_v[], string tag);
    bit d, e; int t;
    start_req(1, sram);
    wait_end(d, e, t);
    chk({tag, " done"}, {d, e}, 2'b10);
    chk_seq(tag, exp_v);
  endtask

  task automatic t_down_bp_err();
    bit d, e; int t;
    bp_err_mode = 1;
    start_req(0, 1);
    wait_end(d, e, t);
    bp_err_mode = 0;
    chk("R12 err", {d, e}, 2'b01);
    chk_seq("R12 no step after error", '{27, 25});
    chk("R12 ctl unchanged", ctl_o, 9'h00D);
  endtask

  task automatic t_down_stuck();
    bit d, e; int t, dt;
    ack_stuck = 1;
    start_req(0, 0);
    wait_end(d, e, t);
    chk("R10 err", {d, e}, 2'b01);
    chk_seq("R10 abort after switch drop", '{27, 25, 19, 21, 20, 18, 3, 9, 0, 4});
    dt = t - t_of(4);
    chk("R10 timeout window", (dt >= TMO && dt <= TMO + 2), 1);
    ack_stuck = 0;
    repeat (5) @(negedge clk_i);
    t_down(0, '{27, 25, 19, 21, 20, 18, 6}, "R4 recovery down");
  endtask

  task automatic t_up_bp_err();
    bp_err_mode = 1;
    t_up(0, '{27, 5, 7, 8, 2, 1, 19, 22, 23, 18, 25}, "R11 up with bus error");
    bp_err_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (6) @(negedge clk_i);
    t_reset();
    t_up_first();
    t_down(1, '{27, 25, 17, 19, 21, 20, 18, 3, 9, 0, 4, 6}, "R3 R4 down with SRAM");
    t_up(1, '{27, 5, 7, 8, 2, 1, 19, 22, 23, 18, 16, 25}, "R7 restore then R9 SRAM");
    t_up(1, '{27, 25}, "R7 flag cleared");
    t_down(0, '{27, 25, 19, 21, 20, 18, 3, 9, 0, 4, 6}, "R8 down no SRAM");
    t_up(0, '{27, 5, 7, 8, 2, 1, 19, 22, 23, 18, 25}, "R8 up no SRAM");
    chk("R8 SRAM bit", ctl_o[8], 0);
    t_down_bp_err();
    t_down_stuck();
    t_up_bp_err();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule